// File: doc/BRIEF.md
# Ethernet MAC Interrupt Event Unit

This block gathers event and error indications from an Ethernet MAC into one 32-bit event register. Each implemented bit stays set until software clears it by writing 1 to it. A mask register with the same layout selects which events raise the interrupt output. The interrupt output is the registered OR of the masked event bits.

Four of the events come from detectors inside the block. A heartbeat checker opens a window after each transmission and reports an error when no collision pulse arrives inside that window. Two frame-length guards, one for receive and one for transmit, count bytes and flag a frame that grows past a programmable maximum length. The frame itself is not cut short. A graceful-stop tracker takes a stop request from one of three sources: a software stop bit, a software pause-frame request bit, or a received pause frame. It waits for the frame in progress to finish, moves the transmitter into a pause state and reports that the stop is complete. The remaining events are one-cycle pulses from the MAC, and the block latches them directly.

Software reaches four word registers through a simple write-strobe and address port. The read data is combinational from the registers.

Top module: `mac_irq_unit`

## Requirements
- R1: After reset the event, mask and control registers are 0, the maximum length register holds 1518, `irq` is 0 and `tx_paused` is 0. Event and mask bits 26:24, 22, 16 and 15:0 always read as 0.
- R2: Register addresses are 0 event, 1 mask, 2 maximum length and 3 control. Writing 1 to an event bit clears it, and writing 0 leaves it unchanged. The maximum length register keeps `wdata[10:0]`. The control register keeps bit 0 (heartbeat check enable), bit 1 (software stop) and bit 2 (software pause request).
- R3: When a hardware set and a write-1 clear hit the same event bit in the same cycle, the bit ends up set.
- R4: A one-cycle pulse on an event input sets its bit at the next clock edge. The mapping is `tx_end` to 27, `mii_done` to 23, `late_col` to 21, `retry_lim` to 20, `tx_unf` to 19, `tx_ferr` to 18 and `rx_ferr` to 17.
- R5: With heartbeat checking enabled, let `tx_end` be high in cycle T. If `col_in` stays low through cycles T+1 to T+HB_WIN, bit 31 sets at the edge that ends cycle T+HB_WIN.
- R6: A `col_in` pulse in any cycle of the heartbeat window prevents bit 31 from setting. With checking disabled, bit 31 never sets.
- R7: Bit 30 sets on the first received byte whose running count exceeds the maximum length. It sets at most once per frame. A new frame starts with `rx_sof` together with its first byte.
- R8: Bit 29 follows the same rule for transmit bytes, using `tx_sof` and `tx_bvalid`.
- R9: When a stop request is present (software stop, software pause request, or a latched `pause_rx` pulse that `pause_end` releases), the tracker waits until `tx_busy` is low. It then raises `tx_paused` and sets bit 28. `tx_paused` falls once no request remains.
- R10: `irq` is 1 exactly one cycle after the event register and the mask register share a set bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the selected register |
| tx_end | input | 1 | Pulse: a frame has finished transmitting |
| col_in | input | 1 | Collision indication from the transceiver |
| tx_sof | input | 1 | First transmit byte of a frame |
| tx_bvalid | input | 1 | One transmit byte this cycle |
| rx_sof | input | 1 | First receive byte of a frame |
| rx_bvalid | input | 1 | One receive byte this cycle |
| tx_busy | input | 1 | Transmitter has a frame in progress |
| pause_rx | input | 1 | Pulse: a valid pause frame has been received |
| pause_end | input | 1 | Pulse: the received pause has expired |
| mii_done | input | 1 | Pulse: a management frame has completed |
| late_col | input | 1 | Pulse: late collision |
| retry_lim | input | 1 | Pulse: retry limit reached |
| tx_unf | input | 1 | Pulse: transmit FIFO underrun |
| tx_ferr | input | 1 | Pulse: transmit FIFO error |
| rx_ferr | input | 1 | Pulse: receive FIFO error |
| tx_paused | output | 1 | Transmitter is held in the pause state |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that HB_WIN is at least 2. They also assume that `rx_sof` and `tx_sof` only ever come together with a byte strobe, and that the MAC starts no new frame while `tx_paused` is high. The stimulus keeps to these rules. It raises a start-of-frame only with a byte, it drives a single `tx_end` pulse per heartbeat window, and it changes `tx_busy` only while the tracker is running or draining. All event and register inputs are driven on the falling clock edge, so each register sees them at the next rising edge.

// File: rtl/mac_irq_pkg.sv
// Package mac_irq_pkg
// Holds the register addresses and event bit positions that the interrupt
// event unit and its bench share. Assumes a 32-bit register word.
package mac_irq_pkg;

    typedef enum logic [1:0] {
        A_EVENT  = 2'd0,
        A_MASK   = 2'd1,
        A_MAXLEN = 2'd2,
        A_CTRL   = 2'd3
    } reg_addr_e;

    localparam int REG_W    = 32;
    localparam int B_HBERR  = 31;
    localparam int B_RXBAB  = 30;
    localparam int B_TXBAB  = 29;
    localparam int B_GSTOP  = 28;
    localparam int B_TXDONE = 27;
    localparam int B_MIIDN  = 23;
    localparam int B_LCOL   = 21;
    localparam int B_RLIM   = 20;
    localparam int B_TXUNF  = 19;
    localparam int B_TXFE   = 18;
    localparam int B_RXFE   = 17;

    localparam logic [REG_W-1:0] IMPL_BITS = 32'hF8BE_0000;

    localparam int CTRL_W    = 3;
    localparam int C_HBEN    = 0;
    localparam int C_STOP    = 1;
    localparam int C_PAUSE   = 2;

endpackage

// File: rtl/mac_hb_check.sv
// Module mac_hb_check
// Heartbeat checker. A transmit-end pulse opens a window of WIN cycles that
// starts on the next cycle. If no collision pulse arrives before the window
// closes, err_p pulses on the last cycle of the window. A new transmit end
// restarts the window. Assumes WIN >= 2.
module mac_hb_check #(
    parameter int WIN = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic tx_end,
    input  logic col,
    output logic err_p
);
    localparam int CW = $clog2(WIN + 1);

    logic [CW-1:0] cnt;
    logic          active;

    // Flag the error on the final window cycle when nothing was seen.
    always_comb begin
        err_p = active && en && !col && (cnt == CW'(1));
    end

    // Window counter: load on transmit end, count down, stop on collision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            cnt    <= '0;
        end else if (tx_end && en) begin
            active <= 1'b1;
            cnt    <= CW'(WIN);
        end else if (active) begin
            if (col || cnt == CW'(1)) begin
                active <= 1'b0;
            end else begin
                cnt <= cnt - CW'(1);
            end
        end
    end

    // R6: a collision inside the window suppresses the error on the next cycle.
    p_col_cancels_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (active && col && !tx_end) |=> !err_p);

    // R6: the error never fires while the checker is disabled.
    p_off_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !err_p);

endmodule

// File: rtl/mac_len_guard.sv
// Module mac_len_guard
// Frame length guard. Counts the bytes of one frame and pulses over_p on the
// first byte whose running count exceeds max_len. It fires at most once per
// frame. sof marks the first byte of a frame and must come with bvalid.
// The count saturates, so very long frames do not wrap.
module mac_len_guard #(
    parameter int LEN_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sof,
    input  logic             bvalid,
    input  logic [LEN_W-1:0] max_len,
    output logic             over_p
);
    localparam int CNT_W = LEN_W + 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] base;
    logic [CNT_W-1:0] nxt;
    logic             flagged;

    // Next count, restarting at a frame start and holding at saturation.
    always_comb begin
        base   = sof ? '0 : cnt;
        nxt    = (&base) ? base : base + CNT_W'(bvalid);
        over_p = bvalid && (nxt > {1'b0, max_len}) && (sof || !flagged);
    end

    // Byte counter and once-per-frame flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            flagged <= 1'b0;
        end else begin
            if (sof || bvalid) begin
                cnt <= nxt;
            end
            if (sof) begin
                flagged <= over_p;
            end else if (over_p) begin
                flagged <= 1'b1;
            end
        end
    end

    // R7/R8: no second pulse within a frame.
    p_once_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
        over_p |=> (!over_p || sof));

    // R8: a pulse only comes with a byte.
    p_pulse_byte_r8: assert property (@(posedge clk) disable iff (!rst_n)
        over_p |-> bvalid);

endmodule

// File: rtl/mac_gstop.sv
// Module mac_gstop
// Graceful-stop tracker. Any of three requests (software stop, software
// pause request, latched received pause) moves it to a drain state. There it
// waits for tx_busy to fall, then enters the pause state and pulses done_p.
// It returns to run once no request remains. Assumes the MAC starts no frame
// while paused is high.
module mac_gstop (
    input  logic clk,
    input  logic rst_n,
    input  logic sw_stop,
    input  logic sw_pause,
    input  logic pause_rx,
    input  logic pause_end,
    input  logic tx_busy,
    output logic paused,
    output logic done_p
);
    typedef enum logic [1:0] {S_RUN, S_DRAIN, S_PAUSED} gs_state_e;

    gs_state_e state;
    logic      hw_pend;
    logic      req;

    // Combine the request sources and spot the moment the drain completes.
    always_comb begin
        req    = sw_stop || sw_pause || hw_pend;
        done_p = (state == S_DRAIN) && req && !tx_busy;
        paused = (state == S_PAUSED);
    end

    // Hold a received pause until the MAC says it has expired.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hw_pend <= 1'b0;
        end else if (pause_rx) begin
            hw_pend <= 1'b1;
        end else if (pause_end) begin
            hw_pend <= 1'b0;
        end
    end

    // Run / drain / paused sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_RUN;
        end else begin
            case (state)
                S_RUN:    if (req) state <= S_DRAIN;
                S_DRAIN:  if (!req) state <= S_RUN;
                          else if (!tx_busy) state <= S_PAUSED;
                S_PAUSED: if (!req) state <= S_RUN;
                default:  state <= S_RUN;
            endcase
        end
    end

    // R9: the pause state is only entered from an idle transmitter.
    p_pause_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(paused) |-> $past(!tx_busy));

    // R9: the pause state is only entered while a request stands.
    p_pause_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(paused) |-> $past(req));

endmodule

// File: rtl/mac_evt_regs.sv
// Module mac_evt_regs
// Register block. Holds the write-one-to-clear event register, the mask,
// the maximum frame length and the control bits. It also produces the
// registered interrupt. A hardware set wins over a same-cycle clear.
module mac_evt_regs
    import mac_irq_pkg::*;
#(
    parameter int LEN_W      = 11,
    parameter int MAXLEN_RST = 1518
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [1:0]       addr,
    input  logic [REG_W-1:0] wdata,
    input  logic [REG_W-1:0] set_i,
    output logic [REG_W-1:0] rdata,
    output logic [LEN_W-1:0] max_len,
    output logic             hb_en,
    output logic             sw_stop,
    output logic             sw_pause,
    output logic             irq
);
    logic [REG_W-1:0]  ev;
    logic [REG_W-1:0]  mask;
    logic [CTRL_W-1:0] ctrl;
    logic [REG_W-1:0]  clr;
    reg_addr_e         sel;

    // Decode the address and the write-one-to-clear vector.
    always_comb begin
        sel = reg_addr_e'(addr);
        clr = (wr && sel == A_EVENT) ? wdata : '0;
    end

    // Event register: clear by writing 1, set from hardware with priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ev <= '0;
        end else begin
            ev <= ((ev & ~clr) | set_i) & IMPL_BITS;
        end
    end

    // Mask, length and control registers written directly.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask    <= '0;
            max_len <= LEN_W'(MAXLEN_RST);
            ctrl    <= '0;
        end else if (wr) begin
            case (sel)
                A_MASK:   mask    <= wdata & IMPL_BITS;
                A_MAXLEN: max_len <= wdata[LEN_W-1:0];
                A_CTRL:   ctrl    <= wdata[CTRL_W-1:0];
                default:  ;
            endcase
        end
    end

    // Registered interrupt from masked events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else begin
            irq <= |(ev & mask);
        end
    end

    // Read mux and control fan-out.
    always_comb begin
        hb_en    = ctrl[C_HBEN];
        sw_stop  = ctrl[C_STOP];
        sw_pause = ctrl[C_PAUSE];
        case (sel)
            A_EVENT:  rdata = ev;
            A_MASK:   rdata = mask;
            A_MAXLEN: rdata = REG_W'(max_len);
            default:  rdata = REG_W'(ctrl);
        endcase
    end

    // R1: reserved positions of event and mask stay zero.
    p_reserved_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ((ev | mask) & ~IMPL_BITS) == '0);

    // R2: a written 1 clears the bit unless hardware set it that cycle.
    p_w1c_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && sel == A_EVENT) |=> ((ev & $past(wdata) & ~$past(set_i)) == '0));

    // R3: every hardware set is visible after the edge.
    p_set_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((ev & $past(set_i & IMPL_BITS)) == $past(set_i & IMPL_BITS)));

    // R10: the interrupt rises only after a masked event existed.
    p_irq_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past((ev & mask) != '0));

endmodule

// File: rtl/mac_irq_unit.sv
// Module mac_irq_unit
// Top of the Ethernet MAC interrupt event unit. Builds the event set vector
// from the heartbeat checker, the two length guards, the graceful-stop
// tracker and the direct MAC pulses, and hands it to the register block.
// Assumes all inputs are synchronous to clk.
module mac_irq_unit
    import mac_irq_pkg::*;
#(
    parameter int HB_WIN     = 8,
    parameter int LEN_W      = 11,
    parameter int MAXLEN_RST = 1518
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        tx_end,
    input  logic        col_in,
    input  logic        tx_sof,
    input  logic        tx_bvalid,
    input  logic        rx_sof,
    input  logic        rx_bvalid,
    input  logic        tx_busy,
    input  logic        pause_rx,
    input  logic        pause_end,
    input  logic        mii_done,
    input  logic        late_col,
    input  logic        retry_lim,
    input  logic        tx_unf,
    input  logic        tx_ferr,
    input  logic        rx_ferr,
    output logic        tx_paused,
    output logic        irq
);
    localparam int NDIR = 2;

    logic [LEN_W-1:0] max_len;
    logic             hb_en;
    logic             sw_stop;
    logic             sw_pause;
    logic             hb_err;
    logic             gs_done;
    logic [NDIR-1:0]  dir_sof;
    logic [NDIR-1:0]  dir_bv;
    logic [NDIR-1:0]  dir_over;
    logic [REG_W-1:0] ev_set;

    // Gather the per-direction byte strobes: index 0 receive, 1 transmit.
    always_comb begin
        dir_sof = {tx_sof, rx_sof};
        dir_bv  = {tx_bvalid, rx_bvalid};
    end

    mac_hb_check #(.WIN(HB_WIN)) u_hb (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (hb_en),
        .tx_end (tx_end),
        .col    (col_in),
        .err_p  (hb_err)
    );

    for (genvar d = 0; d < NDIR; d++) begin : g_len
        mac_len_guard #(.LEN_W(LEN_W)) u_len (
            .clk     (clk),
            .rst_n   (rst_n),
            .sof     (dir_sof[d]),
            .bvalid  (dir_bv[d]),
            .max_len (max_len),
            .over_p  (dir_over[d])
        );
    end

    mac_gstop u_gs (
        .clk       (clk),
        .rst_n     (rst_n),
        .sw_stop   (sw_stop),
        .sw_pause  (sw_pause),
        .pause_rx  (pause_rx),
        .pause_end (pause_end),
        .tx_busy   (tx_busy),
        .paused    (tx_paused),
        .done_p    (gs_done)
    );

    // Place each event source on its register bit.
    always_comb begin
        ev_set           = '0;
        ev_set[B_HBERR]  = hb_err;
        ev_set[B_RXBAB]  = dir_over[0];
        ev_set[B_TXBAB]  = dir_over[1];
        ev_set[B_GSTOP]  = gs_done;
        ev_set[B_TXDONE] = tx_end;
        ev_set[B_MIIDN]  = mii_done;
        ev_set[B_LCOL]   = late_col;
        ev_set[B_RLIM]   = retry_lim;
        ev_set[B_TXUNF]  = tx_unf;
        ev_set[B_TXFE]   = tx_ferr;
        ev_set[B_RXFE]   = rx_ferr;
    end

    mac_evt_regs #(.LEN_W(LEN_W), .MAXLEN_RST(MAXLEN_RST)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (reg_wr),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .set_i    (ev_set),
        .rdata    (reg_rdata),
        .max_len  (max_len),
        .hb_en    (hb_en),
        .sw_stop  (sw_stop),
        .sw_pause (sw_pause),
        .irq      (irq)
    );

    // R4: a direct transmit-done pulse is latched at the next edge.
    p_txdone_latch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_end |=> reg_addr != A_EVENT || reg_rdata[B_TXDONE]);

endmodule

// File: tb/sim_mac_irq_unit.sv
module sim_mac_irq_unit;
    localparam int W = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic tx_end = 0, col_in = 0, tx_sof = 0, tx_bvalid = 0, rx_sof = 0, rx_bvalid = 0;
    logic tx_busy = 0, pause_rx = 0, pause_end = 0, mii_done = 0, late_col = 0;
    logic retry_lim = 0, tx_unf = 0, tx_ferr = 0, rx_ferr = 0;
    logic tx_paused, irq;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 0;

    mac_irq_unit #(.HB_WIN(W), .LEN_W(11), .MAXLEN_RST(1518)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_end(tx_end),
        .col_in(col_in), .tx_sof(tx_sof), .tx_bvalid(tx_bvalid),
        .rx_sof(rx_sof), .rx_bvalid(rx_bvalid), .tx_busy(tx_busy),
        .pause_rx(pause_rx), .pause_end(pause_end), .mii_done(mii_done),
        .late_col(late_col), .retry_lim(retry_lim), .tx_unf(tx_unf),
        .tx_ferr(tx_ferr), .rx_ferr(rx_ferr), .tx_paused(tx_paused), .irq(irq)
    );

    always #10 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        tick(1);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic clr_all();
        wr(2'd0, 32'hFFFF_FFFF);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(2'd0, d); chk("R1 event reset", d, 32'h0);
        rd(2'd1, d); chk("R1 mask reset", d, 32'h0);
        rd(2'd2, d); chk("R1 maxlen reset", d, 32'd1518);
        rd(2'd3, d); chk("R1 ctrl reset", d, 32'h0);
        chk("R1 irq reset", {31'b0, irq}, 32'h0);
        chk("R1 paused reset", {31'b0, tx_paused}, 32'h0);
    endtask

    task automatic t_regs();
        logic [31:0] d;
        wr(2'd1, 32'hFFFF_FFFF);
        rd(2'd1, d); chk("R1 mask reserved zero", d, 32'hF8BE_0000);
        wr(2'd1, 32'h0);
        wr(2'd2, 32'hFFFF_F804);
        rd(2'd2, d); chk("R2 maxlen 11 bits", d, 32'h0000_0004);
        wr(2'd3, 32'hFFFF_FFF8);
        rd(2'd3, d); chk("R2 ctrl 3 bits", d, 32'h0);
    endtask

    task automatic pulse_src(input int b);
        case (b)
            27: tx_end = 1; 23: mii_done = 1; 21: late_col = 1; 20: retry_lim = 1;
            19: tx_unf = 1; 18: tx_ferr = 1; default: rx_ferr = 1;
        endcase
        tick(1);
        tx_end = 0; mii_done = 0; late_col = 0; retry_lim = 0;
        tx_unf = 0; tx_ferr = 0; rx_ferr = 0;
    endtask

    task automatic t_direct();
        logic [31:0] d;
        int bits[7] = '{27, 23, 21, 20, 19, 18, 17};
        foreach (bits[i]) begin
            pulse_src(bits[i]);
            rd(2'd0, d); chk($sformatf("R4 bit %0d set", bits[i]), d, 32'h1 << bits[i]);
            clr_all();
            rd(2'd0, d); chk($sformatf("R2 bit %0d cleared", bits[i]), d, 32'h0);
        end
    endtask

    task automatic t_w1c();
        logic [31:0] d;
        late_col = 1; retry_lim = 1; tick(1); late_col = 0; retry_lim = 0;
        wr(2'd0, 32'h0);
        rd(2'd0, d); chk("R2 write 0 keeps", d, 32'h0030_0000);
        wr(2'd0, 32'h0020_0000);
        rd(2'd0, d); chk("R2 write 1 clears one", d, 32'h0010_0000);
        clr_all();
        reg_wr = 1; reg_addr = 2'd0; reg_wdata = 32'h0800_0000; tx_end = 1;
        tick(1);
        reg_wr = 0; reg_wdata = 0; tx_end = 0;
        rd(2'd0, d); chk("R3 set beats clear", d, 32'h0800_0000);
        clr_all();
    endtask

    task automatic t_hb();
        logic [31:0] d;
        wr(2'd3, 32'h1);
        tx_end = 1; tick(1); tx_end = 0;
        tick(W - 1);
        rd(2'd0, d); chk("R5 no error before window end", d & 32'h8000_0000, 32'h0);
        tick(1);
        rd(2'd0, d); chk("R5 error after window", d & 32'h8000_0000, 32'h8000_0000);
        clr_all();
        tx_end = 1; tick(1); tx_end = 0;
        tick(W - 1);
        col_in = 1; tick(1); col_in = 0;
        tick(2);
        rd(2'd0, d); chk("R6 late-window collision cancels", d & 32'h8000_0000, 32'h0);
        tx_end = 1; tick(1); tx_end = 0;
        col_in = 1; tick(1); col_in = 0;
        tick(W + 2);
        rd(2'd0, d); chk("R6 early collision cancels", d & 32'h8000_0000, 32'h0);
        wr(2'd3, 32'h0);
        tx_end = 1; tick(1); tx_end = 0;
        tick(W + 3);
        rd(2'd0, d); chk("R6 disabled never flags", d & 32'h8000_0000, 32'h0);
        clr_all();
    endtask

    task automatic send_bytes(input bit is_tx, input int n);
        for (int i = 0; i < n; i++) begin
            if (is_tx) begin tx_bvalid = 1; tx_sof = (i == 0); end
            else begin rx_bvalid = 1; rx_sof = (i == 0); end
            tick(1);
        end
        tx_bvalid = 0; tx_sof = 0; rx_bvalid = 0; rx_sof = 0;
    endtask

    task automatic t_len(input bit is_tx);
        logic [31:0] d;
        logic [31:0] b = is_tx ? 32'h2000_0000 : 32'h4000_0000;
        string tg = is_tx ? "R8" : "R7";
        wr(2'd2, 32'd4);
        send_bytes(is_tx, 4);
        rd(2'd0, d); chk({tg, " frame at limit"}, d & b, 32'h0);
        send_bytes(is_tx, 5);
        rd(2'd0, d); chk({tg, " frame over limit"}, d & b, b);
        clr_all();
        if (is_tx) tx_bvalid = 1; else rx_bvalid = 1;
        tick(2);
        tx_bvalid = 0; rx_bvalid = 0;
        rd(2'd0, d); chk({tg, " once per frame"}, d & b, 32'h0);
        send_bytes(is_tx, 5);
        rd(2'd0, d); chk({tg, " new frame flags again"}, d & b, b);
        clr_all();
    endtask

    task automatic t_gstop();
        logic [31:0] d;
        tx_busy = 1;
        wr(2'd3, 32'h2);
        tick(4);
        rd(2'd0, d); chk("R9 waits for busy frame", d & 32'h1000_0000, 32'h0);
        chk("R9 not paused while busy", {31'b0, tx_paused}, 32'h0);
        tx_busy = 0; tick(1);
        chk("R9 paused after frame", {31'b0, tx_paused}, 32'h1);
        rd(2'd0, d); chk("R9 stop complete bit", d & 32'h1000_0000, 32'h1000_0000);
        wr(2'd3, 32'h0); tick(1);
        chk("R9 resumes without request", {31'b0, tx_paused}, 32'h0);
        clr_all();
        wr(2'd3, 32'h4); tick(3);
        chk("R9 pause request bit", {31'b0, tx_paused}, 32'h1);
        rd(2'd0, d); chk("R9 pause request event", d & 32'h1000_0000, 32'h1000_0000);
        wr(2'd3, 32'h0); tick(2); clr_all();
        pause_rx = 1; tick(1); pause_rx = 0; tick(4);
        chk("R9 received pause frame", {31'b0, tx_paused}, 32'h1);
        rd(2'd0, d); chk("R9 received pause event", d & 32'h1000_0000, 32'h1000_0000);
        pause_end = 1; tick(1); pause_end = 0; tick(3);
        chk("R9 pause expiry resumes", {31'b0, tx_paused}, 32'h0);
        clr_all();
    endtask

    task automatic t_irq();
        wr(2'd1, 32'h0080_0000);
        late_col = 1; tick(1); late_col = 0;
        tick(2);
        chk("R10 unmasked event no irq", {31'b0, irq}, 32'h0);
        wr(2'd1, 32'h0820_0000);
        clr_all();
        tick(1);
        tx_end = 1; tick(1); tx_end = 0;
        chk("R10 irq one cycle after event", {31'b0, irq}, 32'h0);
        tick(1);
        chk("R10 irq raised", {31'b0, irq}, 32'h1);
        clr_all();
        tick(1);
        chk("R10 irq drops after clear", {31'b0, irq}, 32'h0);
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        t_reset();
        t_regs();
        t_direct();
        t_w1c();
        t_hb();
        t_len(1'b0);
        t_len(1'b1);
        t_gstop();
        t_irq();
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule